// File: doc/BRIEF.md
# Weighted Overlap-Add Channeliser Front End

This block sits in front of a K-point FFT in a uniform filter-bank channeliser. Complex samples enter one per handshake and shift into a window of L stored samples. Once D fresh samples have arrived, the block multiplies every stored sample by its prototype low-pass coefficient. It then cuts the weighted window into L/K segments of K samples each and adds those segments element by element. The result is one K-sample block, which streams out in ascending index order toward the FFT.

The shift per block (D) and the fold length (K) are separate parameters. Channel spacing (fs/K) and per-channel output rate (fs/D) can therefore be chosen independently, provided K/D equals the ratio of output rate to channel spacing. Each block carries a frame number. A downstream rotator uses it to apply the phase correction 2π·k·m·D/K to FFT bin k of block m. The parameters must satisfy two constraints: L is a multiple of K, and D is no larger than K.

Both streams are valid/ready. On the input, a sample is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is low from the edge that takes the D-th sample of a frame until the edge that loads the last beat of that block into the output register. On the output, a beat is consumed when `out_valid` and `out_ready` are both high at a clock edge. While `out_ready` is low, the pending beat is held unchanged and emission of the rest of the block pauses.

Top module: `wola_frontend`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and the first block carries frame number 0. Every stored window sample reads as zero.
- R2: A block of K beats is produced after every D accepted samples. `in_ready` goes low in the cycle after the D-th sample is accepted, and the first beat is valid one cycle later. No sample is accepted while a beat of that block other than the last is pending.
- R3: Let x[n] be the sample accepted n handshakes before the most recent one (n = 0 is the newest). Output beat j equals the rounded value of the sum over s = 0 … L/K−1 of h[s·K+j]·x[s·K+j], divided by 2^(CW−1). The real and imaginary parts are computed independently with the same real coefficients.
- R4: The coefficients form a triangle: h[n] = t(n)·(2^(CW−1)−1) / (L/2), using integer division, where t(n) = n+1 for n < L/2 and t(n) = L−n otherwise.
- R5: The division by 2^(CW−1) rounds to nearest. An exact half rounds to the even neighbour.
- R6: The beats of a block carry `out_idx` = 0, 1, …, K−1 in that order, and `out_last` is 1 only on index K−1.
- R7: Every beat of block m (counted from 0 after reset) carries `out_frame` = m mod 2^FCW.
- R8: While `out_valid` is 1 and `out_ready` is 0, every output port keeps its value at the next edge.
- R9: Cycles with `in_valid` low have no effect. No block appears until the D-th accepted sample, whatever the gaps between samples.
- R10: Sums are kept at full precision. Full-scale inputs of either sign produce the exact rounded result in OW = DW + log2(L/K) bits, with no wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_re | input | DW | Input sample, real part, two's complement |
| in_im | input | DW | Input sample, imaginary part, two's complement |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_re | output | OW | Folded value, real part |
| out_im | output | OW | Folded value, imaginary part |
| out_idx | output | log2(K) | Position of the beat inside the block |
| out_last | output | 1 | Final beat of the block |
| out_frame | output | FCW | Block number modulo 2^FCW |

## Verification
The hardest case to reach is an exact rounding tie. It needs a window whose weighted sum has its low CW−1 bits at precisely one half, and a random stream almost never produces one. The stimulus reaches it from a freshly reset, all-zero window. It feeds D−1 zeros and then one sample v, solved in the bench so that v·h[0] leaves a remainder of exactly one half. That sample, and its negation, give ties with an odd and an even quotient at beat 0. Random back-pressure held across block boundaries, input gaps, and a narrow frame counter that wraps within the run cover the remaining stream corners.

// File: rtl/wola_pkg.sv
package wola_pkg;

  typedef enum logic [0:0] {
    ST_FILL = 1'b0,
    ST_EMIT = 1'b1
  } wola_state_e;

  // Triangular prototype low-pass: peak (2^(cw-1)-1) at the window centre.
  function automatic int tri_coef(input int n, input int taps, input int cw);
    longint ramp;
    longint peak;
    ramp = (n < taps / 2) ? longint'(n + 1) : longint'(taps - n);
    peak = (longint'(1) << (cw - 1)) - 1;
    return int'((ramp * peak) / longint'(taps / 2));
  endfunction

endpackage

// File: rtl/wola_delay_line.sv
module wola_delay_line #(
  parameter int L  = 64,
  parameter int D  = 12,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din_re,
  input  logic signed [DW-1:0] din_im,
  output logic signed [DW-1:0] tap_re [L],
  output logic signed [DW-1:0] tap_im [L],
  output logic                 frame_done
);
  localparam int CNTW = $clog2(D + 1);

  logic [CNTW-1:0] fill_cnt;

  // Newest sample at tap 0, oldest at tap L-1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) begin
        tap_re[i] <= '0;
        tap_im[i] <= '0;
      end
    end else if (shift_en) begin
      tap_re[0] <= din_re;
      tap_im[0] <= din_im;
      for (int i = 1; i < L; i++) begin
        tap_re[i] <= tap_re[i-1];
        tap_im[i] <= tap_im[i-1];
      end
    end
  end

  assign frame_done = shift_en && (fill_cnt == CNTW'(D - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (frame_done) begin
      fill_cnt <= '0;
    end else if (shift_en) begin
      fill_cnt <= fill_cnt + 1'b1;
    end
  end

  // R2: the per-frame sample counter never reaches D
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt < CNTW'(D));

  // R9: no accepted sample, no progress of the frame count
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(fill_cnt));

endmodule

// File: rtl/wola_coef_rom.sv
module wola_coef_rom #(
  parameter int K  = 16,
  parameter int L  = 64,
  parameter int CW = 16
) (
  input  logic [$clog2(K)-1:0] idx,
  output logic signed [CW-1:0] coef [L/K]
);
  import wola_pkg::*;

  localparam int SEG = L / K;
  localparam int AW  = (L > 1) ? $clog2(L) : 1;

  logic signed [CW-1:0] table_q [L];

  for (genvar n = 0; n < L; n++) begin : g_tap
    localparam logic signed [CW-1:0] HV = CW'(tri_coef(n, L, CW));
    assign table_q[n] = HV;
  end

  for (genvar s = 0; s < SEG; s++) begin : g_seg
    logic [AW-1:0] addr;
    assign addr    = AW'(s * K) + AW'(idx);
    assign coef[s] = table_q[addr];
  end

endmodule

// File: rtl/wola_fold.sv
module wola_fold #(
  parameter int K  = 16,
  parameter int L  = 64,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 check_en,
  input  logic [$clog2(K)-1:0] idx,
  input  logic signed [DW-1:0] tap_re [L],
  input  logic signed [DW-1:0] tap_im [L],
  input  logic signed [CW-1:0] coef   [L/K],
  output logic signed [OW-1:0] y_re,
  output logic signed [OW-1:0] y_im
);
  localparam int SEG  = L / K;
  localparam int SEGB = $clog2(SEG);
  localparam int PW   = DW + CW;
  localparam int ACCW = PW + SEGB + 1;
  localparam int SH   = CW - 1;
  localparam int AW   = (L > 1) ? $clog2(L) : 1;
  localparam logic [SH-1:0] HALF = {1'b1, {(SH-1){1'b0}}};

  logic signed [PW-1:0]   prod_re [SEG];
  logic signed [PW-1:0]   prod_im [SEG];
  logic signed [ACCW-1:0] acc_re, acc_im;
  logic signed [ACCW-1:0] rnd_re, rnd_im;

  for (genvar s = 0; s < SEG; s++) begin : g_mul
    logic [AW-1:0] pos;
    assign pos        = AW'(s * K) + AW'(idx);
    assign prod_re[s] = PW'(tap_re[pos]) * PW'(coef[s]);
    assign prod_im[s] = PW'(tap_im[pos]) * PW'(coef[s]);
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int s = 0; s < SEG; s++) begin
      acc_re = acc_re + ACCW'(prod_re[s]);
      acc_im = acc_im + ACCW'(prod_im[s]);
    end
  end

  // Round half to even after dropping SH fraction bits.
  function automatic logic signed [ACCW-1:0] conv_round(input logic signed [ACCW-1:0] a);
    logic signed [ACCW-1:0] q;
    logic [SH-1:0]          frac;
    q    = a >>> SH;
    frac = a[SH-1:0];
    if ((frac > HALF) || ((frac == HALF) && q[0])) q = q + 1'b1;
    return q;
  endfunction

  assign rnd_re = conv_round(acc_re);
  assign rnd_im = conv_round(acc_im);
  assign y_re   = rnd_re[OW-1:0];
  assign y_im   = rnd_im[OW-1:0];

  // R10: the rounded sum always fits the output width
  a_r10_fits_re: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> (rnd_re == {{(ACCW-OW){y_re[OW-1]}}, y_re}));
  a_r10_fits_im: assert property (@(posedge clk) disable iff (!rst_n)
    check_en |-> (rnd_im == {{(ACCW-OW){y_im[OW-1]}}, y_im}));

endmodule

// File: rtl/wola_frontend.sv
module wola_frontend #(
  parameter int K   = 16,
  parameter int D   = 12,
  parameter int L   = 64,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int FCW = 8,
  parameter int OW  = DW + $clog2(L / K)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [DW-1:0]   in_re,
  input  logic signed [DW-1:0]   in_im,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [OW-1:0]   out_re,
  output logic signed [OW-1:0]   out_im,
  output logic [$clog2(K)-1:0]   out_idx,
  output logic                   out_last,
  output logic [FCW-1:0]         out_frame
);
  import wola_pkg::*;

  localparam int IW  = $clog2(K);
  localparam int SEG = L / K;

  wola_state_e          state_q;
  logic [IW-1:0]        issue_idx;
  logic [FCW-1:0]       frame_q;
  logic                 accept, frame_done, load_beat;
  logic signed [DW-1:0] tap_re [L];
  logic signed [DW-1:0] tap_im [L];
  logic signed [CW-1:0] coef   [SEG];
  logic signed [OW-1:0] fold_re, fold_im;

  assign in_ready  = (state_q == ST_FILL);
  assign accept    = in_valid && in_ready;
  assign load_beat = (state_q == ST_EMIT) && (!out_valid || out_ready);

  wola_delay_line #(.L(L), .D(D), .DW(DW)) u_line (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (accept),
    .din_re    (in_re),
    .din_im    (in_im),
    .tap_re    (tap_re),
    .tap_im    (tap_im),
    .frame_done(frame_done)
  );

  wola_coef_rom #(.K(K), .L(L), .CW(CW)) u_rom (
    .idx (issue_idx),
    .coef(coef)
  );

  wola_fold #(.K(K), .L(L), .DW(DW), .CW(CW), .OW(OW)) u_fold (
    .clk     (clk),
    .rst_n   (rst_n),
    .check_en(load_beat),
    .idx     (issue_idx),
    .tap_re  (tap_re),
    .tap_im  (tap_im),
    .coef    (coef),
    .y_re    (fold_re),
    .y_im    (fold_im)
  );

  // Block sequencer: window frozen while a block is issued.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_FILL;
      issue_idx <= '0;
      frame_q   <= '0;
    end else begin
      case (state_q)
        ST_FILL: begin
          if (frame_done) begin
            state_q   <= ST_EMIT;
            issue_idx <= '0;
          end
        end
        ST_EMIT: begin
          if (load_beat) begin
            issue_idx <= issue_idx + 1'b1;
            if (issue_idx == IW'(K - 1)) begin
              state_q <= ST_FILL;
              frame_q <= frame_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  // Output register slice.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_idx   <= '0;
      out_last  <= 1'b0;
      out_frame <= '0;
    end else if (load_beat) begin
      out_valid <= 1'b1;
      out_re    <= fold_re;
      out_im    <= fold_im;
      out_idx   <= issue_idx;
      out_last  <= (issue_idx == IW'(K - 1));
      out_frame <= frame_q;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled beat holds every field
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                   && $stable(out_idx) && $stable(out_last) && $stable(out_frame)));

  // R6: a consumed non-final beat is followed at once by the next index
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

  // R7: frame number is constant inside a block
  a_r7_frame_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_frame == $past(out_frame)));

  // R2: no input accepted while a block is still being issued
  a_r2_no_accept_mid_block: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);

  // R6: last flag only with the top index
  a_r6_last_top: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_idx == IW'(K - 1)));

endmodule

// File: tb/wola_frontend_test.sv
module wola_frontend_test;
  localparam int K   = 16;
  localparam int D   = 12;
  localparam int L   = 64;
  localparam int DW  = 16;
  localparam int CW  = 16;
  localparam int FCW = 4;
  localparam int OW  = DW + $clog2(L / K);
  localparam int IW  = $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [OW-1:0] out_re, out_im;
  logic [IW-1:0] out_idx;
  logic out_last;
  logic [FCW-1:0] out_frame;

  always #2 clk = ~clk;

  wola_frontend #(.K(K), .D(D), .L(L), .DW(DW), .CW(CW), .FCW(FCW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
    .out_idx(out_idx), .out_last(out_last), .out_frame(out_frame)
  );

  int nchk = 0;
  int nerr = 0;
  bit rdy_rand = 0;
  bit done = 0;

  longint hist_re [L];
  longint hist_im [L];
  int in_cnt = 0;
  int blk = 0;

  longint q_re[$], q_im[$];
  int     q_idx[$], q_frame[$];
  string  q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R4: triangular prototype
  function automatic longint hcoef(input int n);
    longint t;
    t = (n < L / 2) ? n + 1 : L - n;
    return (t * ((1 << (CW - 1)) - 1)) / (L / 2);
  endfunction

  // R5: nearest, ties to even
  function automatic longint rnd_even(input longint s);
    longint q, r;
    q = s >>> (CW - 1);
    r = s - (q <<< (CW - 1));
    if (r > (longint'(1) << (CW - 2))) q = q + 1;
    else if (r == (longint'(1) << (CW - 2)) && q[0]) q = q + 1;
    return q;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < L; i++) begin hist_re[i] = 0; hist_im[i] = 0; end
    in_cnt = 0; blk = 0;
    q_re.delete(); q_im.delete(); q_idx.delete(); q_frame.delete(); q_tag.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: one sample, updates the model and scoreboard (R3)
  task automatic send(input int re, input int im, input string tag);
    longint sr, si;
    in_re = DW'(re); in_im = DW'(im); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = L - 1; i > 0; i--) begin hist_re[i] = hist_re[i-1]; hist_im[i] = hist_im[i-1]; end
    hist_re[0] = re; hist_im[0] = im;
    in_cnt++;
    if (in_cnt == D) begin
      in_cnt = 0;
      for (int j = 0; j < K; j++) begin
        sr = 0; si = 0;
        for (int s = 0; s < L / K; s++) begin
          sr += hcoef(s * K + j) * hist_re[s * K + j];
          si += hcoef(s * K + j) * hist_im[s * K + j];
        end
        q_re.push_back(rnd_even(sr)); q_im.push_back(rnd_even(si));
        q_idx.push_back(j); q_frame.push_back(blk % (1 << FCW));
        q_tag.push_back(tag);
      end
      blk++;
    end
  endtask

  task automatic drain();
    int guard = 0;
    while (q_re.size() != 0 && guard < 4000) begin @(negedge clk); guard++; end
    chk(q_re.size() == 0, "R2", "pending beats after drain", q_re.size(), 0);
  endtask

  // Monitor: pops and compares on each consumed beat
  initial begin
    bit hold_prev = 0;
    longint h_re = 0, h_im = 0;
    int h_idx = 0;
    string tg;
    forever begin
      @(negedge clk);
      if (!rst_n) begin hold_prev = 0; out_ready = 1'b1; continue; end
      if (hold_prev)
        chk(out_valid && longint'(out_re) == h_re && longint'(out_im) == h_im && int'(out_idx) == h_idx,
            "R8", "stalled beat changed", longint'(out_re), h_re);
      out_ready = rdy_rand ? (($urandom % 4) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (q_re.size() == 0) begin
          chk(0, "R2", "unexpected beat", int'(out_idx), -1);
        end else begin
          tg = q_tag.pop_front();
          chk(longint'(out_re) == q_re[0], tg, "out_re", longint'(out_re), q_re[0]);
          chk(longint'(out_im) == q_im[0], tg, "out_im", longint'(out_im), q_im[0]);
          chk(int'(out_idx) == q_idx[0], "R6", "out_idx", out_idx, q_idx[0]);
          chk(out_last == (q_idx[0] == K - 1), "R6", "out_last", out_last, q_idx[0] == K - 1);
          chk(int'(out_frame) == q_frame[0], "R7", "out_frame", out_frame, q_frame[0]);
          void'(q_re.pop_front()); void'(q_im.pop_front());
          void'(q_idx.pop_front()); void'(q_frame.pop_front());
        end
      end
      hold_prev = out_valid && !out_ready;
      h_re = longint'(out_re); h_im = longint'(out_im); h_idx = int'(out_idx);
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int tie_v;
    model_clear();
    do_reset();

    // R1: reset state
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // R9: gaps before the frame completes produce nothing
    for (int i = 0; i < D - 1; i++) begin
      send(100 * i - 500, 37 - 11 * i, "R9");
      repeat (i % 3) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid before D samples", out_valid, 0);
    chk(in_ready == 1'b1, "R9", "in_ready before D samples", in_ready, 1);
    send(1234, -4321, "R1");
    // R2: timing of the block start
    chk(in_ready == 1'b0, "R2", "in_ready after D-th sample", in_ready, 1'b0);
    chk(out_valid == 1'b0, "R2", "out_valid one cycle after", out_valid, 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "out_valid two cycles after", out_valid, 1);
    drain();

    // R3: ramps, consumer always ready
    for (int f = 0; f < 5 * D; f++) send(f * 517 - 15000, 9000 - f * 301, "R3");
    drain();

    // R7 with R8 and R9: random data, random stalls, random gaps, frame wrap
    rdy_rand = 1;
    for (int f = 0; f < 30 * D; f++) begin
      send(int'($urandom % 65536) - 32768, int'($urandom % 65536) - 32768, "R7");
      if (($urandom % 3) == 0) repeat (1 + $urandom % 3) @(negedge clk);
    end
    drain();
    rdy_rand = 0;

    // R10: full-scale negative then positive
    do_reset();
    for (int f = 0; f < 8 * D; f++) send(-32768, -32768, "R10");
    for (int f = 0; f < 8 * D; f++) send(32767, -32768, "R10");
    drain();

    // R4: impulse walks through the window
    do_reset();
    send(16384, -16384, "R4");
    for (int f = 1; f < 7 * D; f++) send(0, 0, "R4");
    drain();

    // R5: exact ties at beat 0, odd and even quotient
    tie_v = 0;
    for (int v = 1; v < 32768; v++)
      if (((longint'(v) * hcoef(0)) & 32'h7fff) == 32'h4000 && tie_v == 0) tie_v = v;
    chk(tie_v != 0, "R5", "tie value found", tie_v, 1);
    do_reset();
    for (int i = 0; i < D - 1; i++) send(0, 0, "R5");
    send(tie_v, -tie_v, "R5");
    drain();
    do_reset();
    for (int i = 0; i < D - 1; i++) send(0, 0, "R5");
    send(-tie_v, tie_v, "R5");
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule